// File: doc/BRIEF.md
# Two-Byte Serial Converter Reader

This block is a serial-bus master that fetches one 12-bit sample from a converter whose frame would need fifteen clocks. A byte-oriented port cannot issue fifteen clocks, so the block runs two 8-bit segments back to back under a single chip-select window, sixteen clocks in all. The converter changes its data on falling serial-clock edges. The block takes one bit on every rising edge, in either clock polarity.

The first two captured bits carry no information. The third is a null bit that must be zero. Eleven down to seven follow, then six down to zero, and last a repeat of bit one. The block drops the junk bits and the repeat, and returns the 12 data bits right-justified. It compares the null bit and the repeated bit against their expected values and reports a frame error when either disagrees. A one-cycle done pulse marks each new result.

A host starts a read with a one-cycle strobe. It selects the clock polarity and a half-period length counted in system clocks. Both settings are taken when the strobe is accepted.

Top module: `adc_seg_reader`

## Requirements
- R1: After reset, chip select is high (inactive), done is low, and result and error flag are zero.
- R2: Each accepted start produces one chip-select low window in which the serial clock changes level exactly 32 times, with exactly 16 rising edges.
- R3: While chip select is high, the serial clock rests at the polarity input level (0 = idles low, 1 = idles high), following it one system clock later; in both polarities data is sampled on rising serial-clock edges.
- R4: With captured bits numbered 1 to 16 in arrival order, the result is bits 4..15, with bit 4 as result bit 11 and bit 15 as result bit 0.
- R5: The error flag is 1 when captured bit 3 (the null bit) is 1.
- R6: The error flag is 1 when captured bit 16 differs from captured bit 14 (result bit 1).
- R7: With H = div setting, or 1 when the setting is 0, every serial-clock half period lasts H system clocks. Chip select falls H clocks before the first clock edge and rises H clocks after the last one, so it stays low for 33*H system clocks.
- R8: A start strobe that arrives while chip select is low has no effect: the window length and the number of done pulses do not change.
- R9: Done is high for exactly one system clock, on the clock where chip select returns high. Result and error flag change only on that clock.
- R10: The values of captured bits 1 and 2 affect neither the result nor the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to read one sample |
| div_i | input | DIV_W | Serial half-period in system clocks (0 treated as 1) |
| cpol_i | input | 1 | Serial clock idle level |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock |
| miso_i | input | 1 | Serial data from converter |
| result_o | output | RES_W | Right-justified conversion result |
| done_o | output | 1 | One-cycle pulse when result updates |
| frame_err_o | output | 1 | Null bit or repeated bit inconsistent |

## Verification
The hardest situation to reach from the ports is a frame whose data is clean while the bits the block must discard or cross-check are corrupted. This takes a null bit of one, a trailing bit that contradicts bit one, or junk leading bits that mimic data. The bench's converter model builds each frame from a data word plus separate knobs for the two junk bits, the null bit and the repeated bit. It drives them on falling edges counted from the rising edges already seen, so the same model serves both polarities. That model is swept over polarity, several half-period settings including 0 and 1, and a spread of data words. A strobe is injected in the middle of a window to confirm it is ignored.

// File: rtl/adc_seg_pkg.sv
package adc_seg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LEAD  = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_TRAIL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seg_tick.sv
module adc_seg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = run_i && (cnt_q == '0);

  always_comb begin
    half_d = half_q;
    cnt_d  = cnt_q;
    if (restart_i) begin
      half_d = div_eff;
      cnt_d  = div_eff - DIV_W'(1);
    end else if (run_i) begin
      cnt_d = (cnt_q == '0) ? (half_q - DIV_W'(1)) : (cnt_q - DIV_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_seg_ctrl.sv
module adc_seg_ctrl
  import adc_seg_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic busy_o,
  output logic restart_o,
  output logic cs_n_o,
  output logic sclk_o,
  output logic sample_o,
  output logic finish_o
);
  localparam int TOG_N = 2 * FRAME_BITS;
  localparam int TOG_W = $clog2(TOG_N + 1);

  seq_state_e       st_q, st_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;
  logic [TOG_W-1:0] tog_q, tog_d;

  assign busy_o = (st_q != SEQ_IDLE);
  assign cs_n_o = cs_q;
  assign sclk_o = sclk_q;

  always_comb begin
    st_d      = st_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    tog_d     = tog_q;
    restart_o = 1'b0;
    sample_o  = 1'b0;
    finish_o  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        sclk_d = cpol_i;
        if (start_i) begin
          st_d      = SEQ_LEAD;
          cs_d      = 1'b0;
          restart_o = 1'b1;
        end
      end
      SEQ_LEAD: begin
        if (tick_i) begin
          sclk_d   = ~sclk_q;
          sample_o = ~sclk_q;
          tog_d    = TOG_W'(1);
          st_d     = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (tick_i) begin
          sclk_d   = ~sclk_q;
          sample_o = ~sclk_q;
          tog_d    = tog_q + TOG_W'(1);
          if (tog_q == TOG_W'(TOG_N - 1)) st_d = SEQ_TRAIL;
        end
      end
      SEQ_TRAIL: begin
        if (tick_i) begin
          cs_d     = 1'b1;
          finish_o = 1'b1;
          st_d     = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      tog_q  <= '0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      tog_q  <= tog_d;
    end
  end
endmodule

// File: rtl/adc_seg_unpack.sv
module adc_seg_unpack #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             bit_i,
  input  logic             commit_i,
  output logic [RES_W-1:0] result_o,
  output logic             err_o,
  output logic             done_o
);
  // Window keeps null bit, data bits and trailing repeat; junk bits fall out the top.
  localparam int KEEP_W   = RES_W + 2;
  localparam int NULL_POS = RES_W + 1;
  localparam int REP_POS  = 0;
  localparam int B1_POS   = 2;

  logic [KEEP_W-1:0] sh_q, sh_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              err_q, err_d;
  logic              done_q;

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    err_d = err_q;
    if (sample_i) sh_d = {sh_q[KEEP_W-2:0], bit_i};
    if (commit_i) begin
      res_d = sh_q[RES_W:1];
      err_d = sh_q[NULL_POS] | (sh_q[REP_POS] ^ sh_q[B1_POS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      res_q  <= res_d;
      err_q  <= err_d;
      done_q <= commit_i;
    end
  end

  assign result_o = res_q;
  assign err_o    = err_q;
  assign done_o   = done_q;
endmodule

// File: rtl/adc_seg_reader.sv
module adc_seg_reader #(
  parameter int DIV_W    = 8,
  parameter int SEG_BITS = 8,
  parameter int NUM_SEGS = 2,
  parameter int RES_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  input  logic             miso_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             frame_err_o
);
  localparam int FRAME_BITS = SEG_BITS * NUM_SEGS;

  logic busy, restart, tick, sample, finish;

  adc_seg_tick #(.DIV_W(DIV_W)) tick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (busy),
    .div_i     (div_i),
    .tick_o    (tick)
  );

  adc_seg_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cpol_i    (cpol_i),
    .tick_i    (tick),
    .busy_o    (busy),
    .restart_o (restart),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .sample_o  (sample),
    .finish_o  (finish)
  );

  adc_seg_unpack #(.RES_W(RES_W)) unpack_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample),
    .bit_i    (miso_i),
    .commit_i (finish),
    .result_o (result_o),
    .err_o    (frame_err_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/adc_seg_reader_chk.sv
module adc_seg_reader_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cpol_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o,
  input logic             frame_err_o
);
  // R9: done lasts a single clock
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: chip select returns high together with done
  p_cs_rise_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> done_o);

  // R9: result is held between done pulses
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R9: error flag is held between done pulses
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(frame_err_o));

  // R3: idle clock level follows polarity one cycle later
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o) && $past(rst_n)) |-> (sclk_o == $past(cpol_i)));

  // R7: an accepted strobe opens the window on the next clock
  p_start_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && start_i) |=> !cs_n_o);
endmodule

bind adc_seg_reader adc_seg_reader_chk #(.RES_W(RES_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cpol_i      (cpol_i),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .result_o    (result_o),
  .done_o      (done_o),
  .frame_err_o (frame_err_o)
);

// File: tb/adc_seg_reader_tb.sv
module adc_seg_reader_tb_top;
  localparam int DIV_W = 8;
  localparam int RES_W = 12;
  localparam int WD_LIMIT = 190000;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [DIV_W-1:0] div_i;
  logic             cpol_i;
  logic             cs_n_o;
  logic             sclk_o;
  logic             miso_i;
  logic [RES_W-1:0] result_o;
  logic             done_o;
  logic             frame_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  adc_seg_reader #(.DIV_W(DIV_W), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
    .cpol_i(cpol_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .miso_i(miso_i),
    .result_o(result_o), .done_o(done_o), .frame_err_o(frame_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // converter model: bit k is what the k-th rising edge sees
  logic fbits [1:16];
  int   rises = 0;

  always @(negedge cs_n_o) begin
    rises  = 0;
    miso_i <= fbits[1];
  end
  always @(posedge sclk_o) if (!cs_n_o) rises = rises + 1;
  always @(negedge sclk_o) if (!cs_n_o && rises < 16) miso_i <= fbits[rises + 1];

  // frame monitor sampled away from the active edge
  int   low_cnt, tog_cnt, rise_cnt, first_k, last_k, done_cnt;
  int   st_low, st_tog, st_rise, st_lead, st_trail;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done_o) done_cnt = done_cnt + 1;
    if (!cs_n_o) begin
      if (prev_cs) begin
        low_cnt = 0; tog_cnt = 0; rise_cnt = 0; first_k = 0; last_k = 0;
      end
      low_cnt = low_cnt + 1;
      if (!prev_cs) begin
        if (sclk_o != prev_sclk) begin
          tog_cnt = tog_cnt + 1;
          if (sclk_o) rise_cnt = rise_cnt + 1;
          if (first_k == 0) first_k = low_cnt;
          last_k = low_cnt;
        end
      end
    end else if (!prev_cs) begin
      st_low   = low_cnt;
      st_tog   = tog_cnt;
      st_rise  = rise_cnt;
      st_lead  = first_k - 1;
      st_trail = low_cnt - last_k + 1;
    end
    prev_cs   = cs_n_o;
    prev_sclk = sclk_o;
    if (cyc == WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_frame(input logic [RES_W-1:0] code, input logic [1:0] junk,
                            input logic nullv, input logic rep_flip);
    fbits[1] = junk[1];
    fbits[2] = junk[0];
    fbits[3] = nullv;
    for (int j = 1; j <= 12; j++) fbits[3 + j] = code[12 - j];
    fbits[16] = code[1] ^ rep_flip;
  endtask

  task automatic run_frame(input logic [RES_W-1:0] code, input logic [1:0] junk,
                           input logic nullv, input logic rep_flip,
                           input int dv, input logic pol, input bit poke);
    int h;
    int d0;
    int w;
    h = (dv == 0) ? 1 : dv;
    load_frame(code, junk, nullv, rep_flip);
    @(negedge clk);
    div_i = DIV_W'(dv); cpol_i = pol;
    @(negedge clk);
    @(negedge clk);
    d0 = done_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    w = 0;
    while (!done_o && w < 40 * h + 20) begin
      if (poke && w == 10 * h) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      w = w + 1;
    end
    chk(done_o == 1'b1, "R9 done seen", int'(done_o), 1);
    chk(cs_n_o == 1'b1, "R9 cs high with done", int'(cs_n_o), 1);
    chk(result_o == code, "R4 result", int'(result_o), int'(code));
    chk(frame_err_o == (nullv | rep_flip), "R5/R6 error flag",
        int'(frame_err_o), int'(nullv | rep_flip));
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done width", int'(done_o), 0);
    chk(st_tog == 32, "R2 clock transitions", st_tog, 32);
    chk(st_rise == 16, "R2 rising edges", st_rise, 16);
    chk(st_lead == h, "R7 lead", st_lead, h);
    chk(st_trail == h, "R7 trail", st_trail, h);
    chk(st_low == 33 * h, "R7 window length", st_low, 33 * h);
    chk(sclk_o == pol, "R3 idle level after frame", int'(sclk_o), int'(pol));
    if (poke) chk(done_cnt - d0 == 1, "R8 one done for poked frame", done_cnt - d0, 1);
  endtask

  function automatic logic [RES_W-1:0] code_of(input int ci);
    case (ci)
      0: code_of = 12'h000;
      1: code_of = 12'hFFF;
      2: code_of = 12'hAAA;
      3: code_of = 12'h555;
      4: code_of = 12'h800;
      5: code_of = 12'h001;
      default: code_of = RES_W'((ci * 1237 + 91) & 12'hFFF);
    endcase
  endfunction

  initial begin
    int dset [5] = '{0, 1, 2, 3, 6};
    done_cnt = 0;
    rst_n = 1'b0; start_i = 1'b0; div_i = '0; cpol_i = 1'b0; miso_i = 1'b0;
    for (int k = 1; k <= 16; k++) fbits[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 cs after reset", int'(cs_n_o), 1);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    chk(result_o == '0, "R1 result after reset", int'(result_o), 0);
    chk(frame_err_o == 1'b0, "R1 error after reset", int'(frame_err_o), 0);
    chk(sclk_o == 1'b0, "R3 idle low", int'(sclk_o), 0);
    cpol_i = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b1, "R3 idle high", int'(sclk_o), 1);

    // sweep: polarity x half-period x data word, junk bits varied (R10)
    for (int p = 0; p < 2; p++)
      for (int di = 0; di < 5; di++)
        for (int ci = 0; ci < 12; ci++)
          run_frame(code_of(ci), 2'(ci + di), 1'b0, 1'b0, dset[di], p[0], 1'b0);

    // R5: null bit set, data intact
    run_frame(12'h3C5, 2'b00, 1'b1, 1'b0, 2, 1'b0, 1'b0);
    run_frame(12'hC3A, 2'b11, 1'b1, 1'b0, 1, 1'b1, 1'b0);
    // R6: trailing repeat contradicts bit one
    run_frame(12'h002, 2'b01, 1'b0, 1'b1, 1, 1'b0, 1'b0);
    run_frame(12'hFFD, 2'b10, 1'b0, 1'b1, 3, 1'b1, 1'b0);
    // R10: error cleared again by a clean frame with junk all ones
    run_frame(12'h7E1, 2'b11, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    // R8: strobe mid-window ignored
    run_frame(12'h9B4, 2'b10, 1'b0, 1'b0, 3, 1'b0, 1'b1);
    run_frame(12'h4D2, 2'b01, 1'b0, 1'b0, 1, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule